// File: doc/BRIEF.md
# Branch Next-Address Generator

This block is the next-fetch-address stage of a 32-bit RISC front end. Every cycle in which an instruction is presented as valid, it decodes the instruction word and selects the address to fetch next. The choices are the fall-through address, a displacement-based target, or a target read from a link or count register. The result goes into a registered next-address output. The block holds the link register and the count register itself. The link register is written with the return address when a branch asks for it. The count register is loaded through a separate write port.

Branch conditions are evaluated elsewhere. A single condition-met input tells this block whether a conditional form is taken. The block does not decrement the count register, resolve hazards, predict or raise exceptions. All instruction-driven updates are gated by the valid input.

Top module: `branch_next_addr`

## Requirements
- R1: After the active-low asynchronous reset, `next_pc_o`, `lr_o` and `ctr_o` are all zero.
- R2: A word whose top six bits (instruction bits 31:26, bit 31 being the most significant) equal 18 is an unconditional branch. Its 24-bit displacement sits in bits 25:2, the absolute flag in bit 1 and the link flag in bit 0. With the absolute flag clear, the next address is `pc_i` plus the sign-extended displacement shifted left by two.
- R3: With the absolute flag set on opcode 18 or opcode 16, the sign-extended shifted displacement alone is the next address. Negative values wrap to the top of the address space.
- R4: Opcode 16 is a conditional branch with a 14-bit displacement in bits 15:2. When `cond_met_i` is 1, the target is formed as in R2 or R3.
- R5: Any conditional form (opcode 16, or the register forms of R6 and R7) with `cond_met_i` at 0 sets the next address to `pc_i + 4`.
- R6: Opcode 19 with bits 15:11 zero and bits 10:1 equal to 16 branches to the link register with its two low bits cleared, when the condition is met.
- R7: Opcode 19 with bits 15:11 zero and bits 10:1 equal to 528 branches to the count register with its two low bits cleared, when the condition is met.
- R8: In every branch form, taken or not, a link flag of 1 writes `pc_i + 4` into the link register. In the link-register form, the target uses the link value from before this write.
- R9: Any other word is not a branch and sets the next address to `pc_i + 4` without touching the link register. This covers other opcodes, opcode 19 with any other bits 10:1, and opcode 19 with nonzero bits 15:11.
- R10: While `valid_i` is 0, `next_pc_o` and `lr_o` keep their values whatever the instruction word is.
- R11: `ctr_we_i` loads `ctr_wdata_i` into the count register at the next edge, independently of `valid_i`. A count-register branch in the same cycle uses the value from before the write.
- R12: Bits 1:0 of `next_pc_o` are always zero, whatever the low bits of `pc_i` and of the register sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and address are valid this cycle |
| insn_i | input | 32 | Current instruction word |
| pc_i | input | 32 | Address of the current instruction |
| cond_met_i | input | 1 | Branch condition result from the condition evaluator |
| ctr_we_i | input | 1 | Count register write enable |
| ctr_wdata_i | input | 32 | Count register write data |
| next_pc_o | output | 32 | Registered next fetch address |
| lr_o | output | 32 | Link register |
| ctr_o | output | 32 | Count register |

## Verification
The hardest case to reach from the ports is a register-indirect branch whose source has nonzero low bits. The link register can only gain such bits through a linking branch issued from an unaligned `pc_i`. The stimulus therefore first issues an unconditional linking branch from an address ending in 3, then a taken link-register branch that also links. That one step shows both the low-bit clearing and the use of the old link value. For the count register, a write with nonzero low bits is issued in the same cycle as a count-register branch. The target must come from the earlier count value.

// File: rtl/brgen_pkg.sv
package brgen_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned LI_W    = 24;
  localparam int unsigned BD_W    = 14;

  localparam logic [5:0] OP_UNCOND = 6'd18;
  localparam logic [5:0] OP_COND   = 6'd16;
  localparam logic [5:0] OP_REGIND = 6'd19;
  localparam logic [9:0] XO_LR     = 10'd16;
  localparam logic [9:0] XO_CTR    = 10'd528;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_DISP = 2'd1,
    KIND_REG  = 2'd2
  } br_kind_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import brgen_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  output br_kind_e          kind_o,
  output logic              needs_cond_o,
  output logic              link_o,
  output logic              abs_o,
  output logic              use_ctr_o,
  output logic [XLEN-1:0]   disp_o
);
  localparam int unsigned LI_EXT = XLEN - LI_W - 2;
  localparam int unsigned BD_EXT = XLEN - BD_W - 2;

  logic [5:0]      opcd;
  logic [LI_W-1:0] li;
  logic [BD_W-1:0] bd;
  logic [4:0]      zero_fld;
  logic [9:0]      xo;

  assign opcd     = insn_i[31:26];
  assign li       = insn_i[25:2];
  assign bd       = insn_i[15:2];
  assign zero_fld = insn_i[15:11];
  assign xo       = insn_i[10:1];

  always_comb begin
    kind_o       = KIND_NONE;
    needs_cond_o = 1'b0;
    link_o       = insn_i[0];
    abs_o        = insn_i[1];
    use_ctr_o    = 1'b0;
    disp_o       = '0;
    unique case (opcd)
      OP_UNCOND: begin
        kind_o = KIND_DISP;
        disp_o = {{LI_EXT{li[LI_W-1]}}, li, 2'b00};
      end
      OP_COND: begin
        kind_o       = KIND_DISP;
        needs_cond_o = 1'b1;
        disp_o       = {{BD_EXT{bd[BD_W-1]}}, bd, 2'b00};
      end
      OP_REGIND: begin
        abs_o = 1'b0;
        if (zero_fld == 5'd0 && (xo == XO_LR || xo == XO_CTR)) begin
          kind_o       = KIND_REG;
          needs_cond_o = 1'b1;
          use_ctr_o    = (xo == XO_CTR);
        end
      end
      default: ;
    endcase
    if (kind_o == KIND_NONE) link_o = 1'b0;
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import brgen_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_kind_e        kind_i,
  input  logic            abs_i,
  input  logic            use_ctr_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic [XLEN-1:0] target_o
);
  localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-2){1'b1}}, 2'b00};

  logic [XLEN-1:0] disp_tgt;
  logic [XLEN-1:0] reg_tgt;

  assign disp_tgt = abs_i ? disp_i : (pc_i + disp_i);
  assign reg_tgt  = use_ctr_i ? ctr_i : lr_i;
  assign target_o = ((kind_i == KIND_REG) ? reg_tgt : disp_tgt) & ALIGN_MASK;
endmodule

// File: rtl/branch_next_addr.sv
module branch_next_addr
  import brgen_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              cond_met_i,
  input  logic              ctr_we_i,
  input  logic [XLEN-1:0]   ctr_wdata_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   lr_o,
  output logic [XLEN-1:0]   ctr_o
);
  localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-2){1'b1}}, 2'b00};
  localparam logic [XLEN-1:0] STEP       = XLEN'(4);

  br_kind_e        kind;
  logic            needs_cond, link, abs_sel, use_ctr, taken;
  logic [XLEN-1:0] disp, target, seq, next_d;
  logic [XLEN-1:0] next_q, lr_q, ctr_q;

  br_decode #(.XLEN(XLEN)) u_dec (
    .insn_i      (insn_i),
    .kind_o      (kind),
    .needs_cond_o(needs_cond),
    .link_o      (link),
    .abs_o       (abs_sel),
    .use_ctr_o   (use_ctr),
    .disp_o      (disp)
  );

  br_target #(.XLEN(XLEN)) u_tgt (
    .kind_i   (kind),
    .abs_i    (abs_sel),
    .use_ctr_i(use_ctr),
    .disp_i   (disp),
    .pc_i     (pc_i),
    .lr_i     (lr_q),
    .ctr_i    (ctr_q),
    .target_o (target)
  );

  assign seq    = pc_i + STEP;
  assign taken  = (kind != KIND_NONE) && (!needs_cond || cond_met_i);
  assign next_d = taken ? target : (seq & ALIGN_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      lr_q   <= '0;
    end else if (valid_i) begin
      next_q <= next_d;
      if (link) lr_q <= seq;  // old lr_q already consumed by target path
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctr_q <= '0;
    else if (ctr_we_i) ctr_q <= ctr_wdata_i;
  end

  assign next_pc_o = next_q;
  assign lr_o      = lr_q;
  assign ctr_o     = ctr_q;

  AST_NPC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_q[1:0] == 2'b00);  // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_q) && $stable(lr_q));  // R10
  AST_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && needs_cond && !cond_met_i
      |=> next_q == (($past(pc_i) + STEP) & ALIGN_MASK));  // R5
  AST_NONBR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind == KIND_NONE
      |=> next_q == (($past(pc_i) + STEP) & ALIGN_MASK) && $stable(lr_q));  // R9
  AST_LINK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind != KIND_NONE && insn_i[0] |=> lr_q == $past(pc_i) + STEP);  // R8
  AST_CTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_we_i |=> ctr_q == $past(ctr_wdata_i));  // R11
  AST_CTR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctr_we_i |=> $stable(ctr_q));  // R11
endmodule

// File: tb/branch_next_addr_tb.sv
`timescale 1ns/1ps
module branch_next_addr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] pc = '0;
  logic        cond = 1'b0;
  logic        ctr_we = 1'b0;
  logic [31:0] ctr_wd = '0;
  logic [31:0] npc, lr, ctr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_npc = '0, m_lr = '0, m_ctr = '0;

  always #4 clk = ~clk;

  branch_next_addr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn), .pc_i(pc),
    .cond_met_i(cond), .ctr_we_i(ctr_we), .ctr_wdata_i(ctr_wd),
    .next_pc_o(npc), .lr_o(lr), .ctr_o(ctr)
  );

  function automatic logic [31:0] mk_b(int d, bit aa, bit lk);
    logic [31:0] dv = d;
    return {6'd18, dv[23:0], aa, lk};
  endfunction
  function automatic logic [31:0] mk_bc(int d, bit aa, bit lk);
    logic [31:0] dv = d;
    return {6'd16, 5'd12, 5'd2, dv[13:0], aa, lk};
  endfunction
  function automatic logic [31:0] mk_reg(int xo, logic [4:0] z, bit lk);
    logic [31:0] xv = xo;
    return {6'd19, 5'd20, 5'd0, z, xv[9:0], lk};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: one instruction, one clock
  task automatic model(bit v, logic [31:0] w, logic [31:0] a, bit c, bit we, logic [31:0] wd);
    int unsigned op = w[31:26];
    longint s;
    logic [31:0] fall = a + 32'd4;
    logic [31:0] dest = fall;
    bit is_br = 0, go = 0;
    if (op == 18) begin
      s = longint'($signed(w[25:2])) * 4;
      is_br = 1; go = 1;
      dest = w[1] ? 32'(s) : 32'(longint'(a) + s);
    end else if (op == 16) begin
      s = longint'($signed(w[15:2])) * 4;
      is_br = 1; go = c;
      dest = w[1] ? 32'(s) : 32'(longint'(a) + s);
    end else if (op == 19 && w[15:11] == 0 && (w[10:1] == 16 || w[10:1] == 528)) begin
      is_br = 1; go = c;
      dest = (w[10:1] == 16) ? m_lr : m_ctr;
    end
    if (!go) dest = fall;
    dest[1:0] = 2'b00;
    if (v) begin
      m_npc = dest;
      if (is_br && w[0]) m_lr = fall;
    end
    if (we) m_ctr = wd;
  endtask

  task automatic step(string req, bit v, logic [31:0] w, logic [31:0] a, bit c,
                      bit we = 0, logic [31:0] wd = '0);
    @(negedge clk);
    valid = v; insn = w; pc = a; cond = c; ctr_we = we; ctr_wd = wd;
    model(v, w, a, c, we, wd);
    @(negedge clk);
    valid = 0; ctr_we = 0;
    check(req, "next_pc", npc, m_npc);
    check(req, "lr", lr, m_lr);
    check(req, "ctr", ctr, m_ctr);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "next_pc", npc, 32'h0);
    check("R1", "lr", lr, 32'h0);
    check("R1", "ctr", ctr, 32'h0);
    rst_n = 1'b1;
    // R2 forward and backward relative
    step("R2", 1, mk_b(32'h40, 0, 0), 32'h0000_1000, 0);
    step("R2", 1, mk_b(-16, 0, 0), 32'h0000_1000, 0);
    step("R2", 1, mk_b(-8, 0, 0), 32'h0000_0010, 1);
    // R3 absolute, positive and negative
    step("R3", 1, mk_b(32'h100, 1, 0), 32'h0000_8000, 0);
    step("R3", 1, mk_b(-4, 1, 0), 32'h0000_8000, 0);
    step("R3", 1, mk_bc(-1, 1, 0), 32'h0000_2000, 1);
    // R4 conditional taken relative
    step("R4", 1, mk_bc(-8, 0, 0), 32'h0000_2000, 1);
    step("R4", 1, mk_bc(32'h1FFF, 0, 0), 32'h0000_2000, 1);
    // R5 not taken
    step("R5", 1, mk_bc(32'h20, 0, 0), 32'h0000_2000, 0);
    // R8 link on unconditional, from unaligned pc (lr gets low bits)
    step("R8", 1, mk_b(32'h10, 0, 1), 32'h0000_0703, 0);
    // R6 + R8 link-register branch with link: old lr is target
    step("R6", 1, mk_reg(16, 5'd0, 1), 32'h0000_0500, 1);
    step("R6", 1, mk_reg(16, 5'd0, 0), 32'h0000_0600, 1);
    step("R5", 1, mk_reg(16, 5'd0, 0), 32'h0000_0600, 0);
    // R8 not-taken conditional still links
    step("R8", 1, mk_bc(32'h40, 0, 1), 32'h0000_3000, 0);
    // R11 count write, then count branch with low bits set
    step("R11", 0, 32'h0, 32'h0, 0, 1, 32'h0000_4007);
    step("R7", 1, mk_reg(528, 5'd0, 0), 32'h0000_0100, 1);
    step("R7", 1, mk_reg(528, 5'd0, 0), 32'h0000_0100, 0);
    // R11 simultaneous write and count branch uses the old value
    step("R11", 1, mk_reg(528, 5'd0, 1), 32'h0000_0200, 1, 1, 32'h0000_9ABD);
    step("R7", 1, mk_reg(528, 5'd0, 0), 32'h0000_0300, 1);
    // R9 non-branches
    step("R9", 1, 32'h3800_0001, 32'h0000_0A00, 1);
    step("R9", 1, mk_reg(16, 5'd3, 1), 32'h0000_0B00, 1);
    step("R9", 1, mk_reg(150, 5'd0, 1), 32'h0000_0C00, 1);
    // R10 invalid slot holds
    step("R10", 0, mk_b(32'h400, 1, 1), 32'h0000_0D00, 1);
    step("R10", 0, mk_bc(-4, 0, 1), 32'h0000_0E00, 1);
    // R12 unaligned pc on plain instruction and relative branch
    step("R12", 1, 32'h7C00_0000, 32'h0000_1003, 0);
    step("R12", 1, mk_b(32'h4, 0, 0), 32'h0000_2002, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule